// File: doc/BRIEF.md
# Serial Control Register Slave for a Signal Routing Switch

This block is a two-wire (I2C-compatible) slave that holds the two 8-bit control registers of a low-speed routing switch. A fast system clock samples SCL and SDA through synchronizers. The block detects START, repeated START and STOP as SDA edges while SCL is high. It then decodes a 7-bit device address, a register pointer byte and data bytes.

A write sends the address with R/W = 0, a pointer byte, and then one or more data bytes. The pointer advances after each byte. A read sets the pointer with a write, then issues a repeated START and the address with R/W = 1. The slave then shifts out register contents, MSB first, for as long as the master acknowledges. The block pulls SDA low through a single drive-enable output that the pad logic turns into an open-drain driver. Both register values are exported continuously to the switch logic. The block takes part on the bus only while the serial-control mode input is high.

Top module: `swctl_i2c_regs`

## Requirements
- R1: After reset, register 0 holds 0x00, register 1 holds 0xAA, and SDA is not driven.
- R2: The device address is binary 0111 in bits [6:3], followed by the strap inputs in bits [2:0]. The address byte carries the address in bits [7:1] and R/W in bit 0. The slave acknowledges (pulls SDA low in the ninth clock) only on a match. On a mismatch it stays silent until the next START.
- R3: In a write (R/W = 0), a pointer byte of 0x00 or 0x01 is acknowledged. Each following data byte is stored into the register the pointer selects and is acknowledged. A register changes only while SCL is low.
- R4: Bits [1:0] of register 0 always read and output as 00, whatever value was written to them.
- R5: The pointer advances by one after each data byte. A data byte aimed past register 1 is not acknowledged and changes nothing.
- R6: A pointer byte above 0x01 is not acknowledged, and it leaves both registers unchanged.
- R7: After a repeated START and a matching address with R/W = 1, the slave shifts out the register at the pointer, MSB first. A master ACK advances to the next register. Reads past register 1 return 0xFF (bus released). SDA drive changes only while SCL is low.
- R8: While the mode input is low, the slave never drives SDA and never changes a register.
- R9: A START seen in the middle of a byte abandons the transfer in progress and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_en | input | 1 | Mode select: 1 = serial control active |
| strap | input | 3 | Low three device-address bits |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_drive_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg0_q | output | 8 | Register 0 value (bits [1:0] always 0) |
| reg1_q | output | 8 | Register 1 value |

## Verification
The timing checks assume that SCL stays in each level for several system clocks longer than the synchronizer and edge-detect latency. Under that assumption, the slave's drive and register updates, which follow a detected SCL fall, still land while the pad SCL is low. The checks also assume the master changes SDA only while SCL is low, except when it signals START or STOP, and that straps and the mode input change only while the bus is idle. The stimulus runs the bus at ten system clocks per quarter bit. It moves SDA one quarter bit after each SCL fall, and it changes straps and the mode only between transactions.

// File: rtl/swctl_pkg.sv
// Shared constants and types for the serial control register slave.
// Assumes an 8-bit byte with a 7-bit address of fixed bits plus straps.
package swctl_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 2;
    localparam int STRAP_W  = 3;
    localparam int FIX_W    = DATA_W - 1 - STRAP_W;
    localparam int BCNT_W   = $clog2(DATA_W + 1);
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    localparam logic [FIX_W-1:0]  FIXED_ADDR = 4'b0111;
    localparam logic [DATA_W-1:0] REG0_RST   = 8'h00;
    localparam logic [DATA_W-1:0] REG1_RST   = 8'hAA;
    localparam logic [DATA_W-1:0] REG0_ZERO  = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_PTR, ST_WDAT, ST_ACK, ST_TX, ST_MACK, ST_TXGO
    } state_t;

    // Reset value of register i.
    function automatic logic [DATA_W-1:0] rst_val(input int i);
        return (i == 1) ? REG1_RST : REG0_RST;
    endfunction

    // Bits of register i that are hard-wired to zero.
    function automatic logic [DATA_W-1:0] zero_mask(input int i);
        return (i == 0) ? REG0_ZERO : '0;
    endfunction
endpackage

// File: rtl/swctl_sync.sv
// Two-flop synchronizer bank for asynchronous bus inputs.
// Assumes an idle level of 1 for every input; resets to that level.
module swctl_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        // Two-stage capture of one input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[g]  <= 1'b1;
                d_out[g] <= 1'b1;
            end else begin
                meta[g]  <= d_in[g];
                d_out[g] <= meta[g];
            end
        end
    end
endmodule

// File: rtl/swctl_busdet.sv
// Bus condition detector: SCL edges plus START and STOP.
// Assumes synchronized inputs; START/STOP are SDA edges while SCL is high.
module swctl_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_p, sda_p;

    // Hold the previous synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Decode edges and bus conditions from the level pairs.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/swctl_regfile.sv
// Control register file with one write port and one read port.
// Assumes a read index beyond the last register returns all ones.
module swctl_regfile
    import swctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [DATA_W-1:0]                  rd_ptr,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_q
);
    localparam logic [DATA_W-1:0] NUM_L = DATA_W'(NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Store one register, clearing its hard-wired bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= rst_val(g);
            else if (wr_en && wr_idx == IDX_W'(g))
                regs_q[g] <= wr_data & ~zero_mask(g);
        end
    end

    // Select the register addressed by the pointer.
    always_comb begin
        if (rd_ptr < NUM_L)
            rd_data = regs_q[rd_ptr[IDX_W-1:0]];
        else
            rd_data = '1;
    end
endmodule

// File: rtl/swctl_i2c_regs.sv
// Two-wire slave front end for the switch control registers.
// Assumes SCL phases last several clk cycles; no clock stretching.
module swctl_i2c_regs
    import swctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               serial_en,
    input  logic [STRAP_W-1:0] strap,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_drive_low,
    output logic [DATA_W-1:0]  reg0_q,
    output logic [DATA_W-1:0]  reg1_q
);
    localparam logic [BCNT_W-1:0] BITS_L = BCNT_W'(DATA_W);
    localparam logic [BCNT_W-1:0] LAST_L = BCNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] NUM_L  = DATA_W'(NUM_REGS);

    logic [1:0]        sync_q;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, bus_start, bus_stop;
    state_t            state, after;
    logic [BCNT_W-1:0] bitcnt;
    logic [DATA_W-1:0] shreg, txsh, ptr, rd_data;
    logic              byte_done, ptr_ok, wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    swctl_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({scl_in, sda_in}), .d_out(sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    swctl_busdet u_det (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    // Decode byte completion and the register write strobe.
    always_comb begin
        byte_done = serial_en & ~bus_start & ~bus_stop & scl_fall & (bitcnt == BITS_L);
        ptr_ok    = ptr < NUM_L;
        wr_en     = byte_done & (state == ST_WDAT) & ptr_ok;
    end

    swctl_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr[IDX_W-1:0]),
        .wr_data(shreg), .rd_ptr(ptr), .rd_data(rd_data), .regs_q(regs_q)
    );

    // Protocol sequencer: address, pointer, write data, read data, acks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            after  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txsh   <= '1;
            ptr    <= '0;
        end else if (!serial_en) begin
            state <= ST_IDLE;
        end else if (bus_start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (bus_stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (scl_rise && bitcnt != BITS_L) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        state  <= ST_IDLE;
                        if (state == ST_ADDR) begin
                            if (shreg[DATA_W-1:1] == {FIXED_ADDR, strap}) begin
                                state <= ST_ACK;
                                after <= shreg[0] ? ST_TX : ST_PTR;
                            end
                        end else if (state == ST_PTR) begin
                            if (shreg < NUM_L) begin
                                ptr   <= shreg;
                                state <= ST_ACK;
                                after <= ST_WDAT;
                            end
                        end else if (ptr_ok) begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_ACK;
                            after <= ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (after == ST_TX) txsh <= rd_data;
                        state <= after;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST_L) begin
                            state <= ST_MACK;
                        end else begin
                            txsh   <= {txsh[DATA_W-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            state <= ST_IDLE;
                        end else begin
                            if (ptr_ok) ptr <= ptr + 1'b1;
                            state <= ST_TXGO;
                        end
                    end
                end
                ST_TXGO: begin
                    if (scl_fall) begin
                        txsh   <= rd_data;
                        bitcnt <= '0;
                        state  <= ST_TX;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Open-drain enable: ack slot or a zero data bit.
    always_comb begin
        sda_drive_low = serial_en & ((state == ST_ACK) | ((state == ST_TX) & ~txsh[DATA_W-1]));
        reg0_q        = regs_q[0];
        reg1_q        = regs_q[1];
    end
endmodule

// File: rtl/swctl_i2c_regs_chk.sv
// Property checker for the register slave, attached by bind.
// Assumes the bus timing stated in the brief's verification section.
module swctl_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       serial_en,
    input logic [2:0] strap,
    input logic       scl_in,
    input logic       sda_in,
    input logic       sda_drive_low,
    input logic [7:0] reg0_q,
    input logic [7:0] reg1_q
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        !rst_n |=> (reg0_q == 8'h00 && reg1_q == 8'hAA && !sda_drive_low)); // R1

    AST_REG0_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg0_q[1:0] == 2'b00); // R4

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_en |-> !sda_drive_low); // R8

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_en |=> ($stable(reg0_q) && $stable(reg1_q))); // R8

    AST_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg0_q) || !$stable(reg1_q)) |-> !scl_in); // R3

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_in); // R7
endmodule

bind swctl_i2c_regs swctl_i2c_regs_chk u_chk (.*);

// File: tb/swctl_i2c_regs_test.sv
module swctl_i2c_regs_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_en = 1'b1;
    logic [2:0] strap = 3'd0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_drive_low;
    logic [7:0] reg0_q, reg1_q;
    wire        sda_bus = sda_m & ~sda_drive_low;

    int n_chk = 0;
    int n_bad = 0;
    int off_drives = 0;
    bit done = 0;

    always #5 clk = ~clk;

    swctl_i2c_regs uut (
        .clk(clk), .rst_n(rst_n), .serial_en(serial_en), .strap(strap),
        .scl_in(scl_m), .sda_in(sda_bus), .sda_drive_low(sda_drive_low),
        .reg0_q(reg0_q), .reg1_q(reg1_q)
    );

    always @(negedge clk) if (rst_n && !serial_en && sda_drive_low) off_drives++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic brestart();
        sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    endtask

    task automatic bstop();
        sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
    endtask

    task automatic wbit(input bit b);
        sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    endtask

    task automatic rbit(output bit b);
        sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq();
    endtask

    // Send a byte; nack = 1 means the slave did not acknowledge.
    task automatic wbyte(input logic [7:0] d, output bit nack);
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(nack);
    endtask

    task automatic rbyte(input bit mnack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
        wbit(mnack);
    endtask

    task automatic wr_regs(input logic [7:0] p, input logic [7:0] d, output bit nack);
        bit n;
        bstart();
        wbyte({4'b0111, strap, 1'b0}, n);
        wbyte(p, nack);
        if (!nack) wbyte(d, nack);
        bstop();
    endtask

    task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
        bit n;
        bstart();
        wbyte({4'b0111, strap, 1'b0}, n);
        wbyte(p, n);
        brestart();
        wbyte({4'b0111, strap, 1'b1}, n);
        rbyte(1'b1, d);
        bstop();
    endtask

    initial begin
        repeat (50000 * 3 + 40000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit n;
        logic [7:0] d, e;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(reg0_q == 8'h00, "R1 reg0 reset", reg0_q, 8'h00);
        check(reg1_q == 8'hAA, "R1 reg1 reset", reg1_q, 8'hAA);
        check(!sda_drive_low, "R1 sda idle in reset", sda_drive_low, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(reg1_q == 8'hAA && !sda_drive_low, "R1 after reset", reg1_q, 8'hAA);

        // R2: address decode over every strap and low-address combination
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            wq();
            for (int a = 0; a < 8; a++) begin
                bstart(); wbyte({4'b0111, 3'(a), 1'b0}, n); bstop();
                check(n == (a != s), "R2 address match", n, (a != s));
            end
            bstart(); wbyte({4'b0110, 3'(s), 1'b0}, n); bstop();
            check(n == 1, "R2 wrong fixed bits", n, 1);
            bstart(); wbyte({4'b1111, 3'(s), 1'b1}, n); bstop();
            check(n == 1, "R2 wrong fixed bits read", n, 1);
        end
        strap = 3'd5;
        wq();

        // R3/R4: write then read back register 0, low bits forced to zero
        for (int v = 0; v < 8; v++) begin
            d = 8'(v * 37) ^ 8'h5B;
            wr_regs(8'h00, d, n);
            check(n == 0, "R3 data ack reg0", n, 0);
            check(reg0_q == (d & 8'hFC), "R4 reg0 port", reg0_q, d & 8'hFC);
            rd_reg(8'h00, e);
            check(e == (d & 8'hFC), "R4 reg0 readback", e, d & 8'hFC);
        end
        // R3/R7: register 1 all bits writable
        for (int v = 0; v < 8; v++) begin
            d = 8'(v * 29) ^ 8'hC3;
            wr_regs(8'h01, d, n);
            check(reg1_q == d, "R3 reg1 port", reg1_q, d);
            rd_reg(8'h01, e);
            check(e == d, "R7 reg1 readback", e, d);
        end

        // R5: auto-increment and write past the last register
        bstart();
        wbyte({4'b0111, strap, 1'b0}, n);
        wbyte(8'h00, n);
        wbyte(8'hE7, n); check(n == 0, "R5 first data ack", n, 0);
        wbyte(8'h19, n); check(n == 0, "R5 second data ack", n, 0);
        wbyte(8'h66, n); check(n == 1, "R5 third data nack", n, 1);
        bstop();
        check(reg0_q == 8'hE4, "R5 reg0 after burst", reg0_q, 8'hE4);
        check(reg1_q == 8'h19, "R5 reg1 after burst", reg1_q, 8'h19);

        // R6: out-of-range pointers
        wr_regs(8'h02, 8'h00, n);
        check(n == 1, "R6 pointer 0x02 nack", n, 1);
        wr_regs(8'h80, 8'h00, n);
        check(n == 1, "R6 pointer 0x80 nack", n, 1);
        check(reg0_q == 8'hE4 && reg1_q == 8'h19, "R6 regs unchanged", {reg0_q, reg1_q}, 16'hE419);

        // R7: burst read across the register end
        bstart();
        wbyte({4'b0111, strap, 1'b0}, n);
        wbyte(8'h00, n);
        brestart();
        wbyte({4'b0111, strap, 1'b1}, n);
        check(n == 0, "R7 read address ack", n, 0);
        rbyte(1'b0, e); check(e == 8'hE4, "R7 burst byte 0", e, 8'hE4);
        rbyte(1'b0, e); check(e == 8'h19, "R7 burst byte 1", e, 8'h19);
        rbyte(1'b1, e); check(e == 8'hFF, "R7 read past end", e, 8'hFF);
        bstop();

        // R8: serial mode off
        serial_en = 0;
        wq();
        wr_regs(8'h01, 8'h33, n);
        check(n == 1, "R8 no ack when off", n, 1);
        check(reg1_q == 8'h19, "R8 reg1 unchanged", reg1_q, 8'h19);
        check(off_drives == 0, "R8 no drive when off", off_drives, 0);
        serial_en = 1;
        wq();

        // R9: START in the middle of a byte restarts the address phase
        bstart();
        wbit(1); wbit(0); wbit(1); wbit(0);
        brestart();
        wbyte({4'b0111, strap, 1'b0}, n);
        check(n == 0, "R9 address ack after abort", n, 0);
        wbyte(8'h01, n);
        wbyte(8'h3C, n);
        bstop();
        check(reg1_q == 8'h3C, "R9 write after abort", reg1_q, 8'h3C);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule